// File: doc/BRIEF.md
# Grouped Timer Interrupt Aggregator

This block collects the interrupt causes of eight timers and folds them into two level interrupt lines for a vectored interrupt controller. Each timer has three cause inputs, delivered as single-cycle event strobes. The counting logic of the timers is not part of the block. Every cause has a sticky pending flag and an enable bit. A timer requests service whenever at least one of its causes is both pending and enabled.

The timers fall into two groups. The four narrow timers (slots 0..3) each hold their enables and their pending flags in one control word. The four wide timers (slots 4..7) hold their enables in their own control words. Their pending flags are packed into byte lanes of one shared status word. The narrow group's requests are ORed onto interrupt line 8 (`irq_tmr16_o`), and the wide group's requests onto interrupt line 7 (`irq_tmr32_o`). Software uses a plain single-cycle register port to set the enables and to clear pending flags by writing ones. Reads are combinational on the address.

Top module: `tmr_irq_agg`

## Requirements
- R1: After reset every enable and every pending flag is zero, every register reads 0, and both interrupt outputs are low.
- R2: Address t (0..3) is the control word of narrow timer t. Bits 14:12 are read/write enables for causes 2..0 (bit 12 is cause 0). Bits 18:16 read back the pending flags of causes 2..0 (bit 16 is cause 0). All other bits read 0.
- R3: Address 4+k (k=0..3) is the control word of wide timer k, with read/write enables in bits 14:12 (bit 12 is cause 0) and all other bits reading 0. Address 8 is the shared status word. Its lanes are: wide timer 0 in bits 26:24, timer 1 in 18:16, timer 2 in 10:8, timer 3 in 2:0, with the lowest bit of each lane being cause 0. All other bits read 0.
- R4: An event strobe sampled high on a clock edge sets its pending flag at that edge, whether or not the matching enable is set. Event bit 3*t+c of `evt16_i` or `evt32_i` is cause c of timer t of that group.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A write to a narrow control word whose pending field is 0 changes only the enables.
- R6: When an event strobe and a clearing write hit the same flag at the same edge, the flag ends up set.
- R7: `irq_tmr16_o` is registered once. It is high on the cycle after any narrow timer has a cause that is both pending and enabled, and low on the cycle after none has.
- R8: `irq_tmr32_o` follows the same rule for the wide timers, using the status-word pending flags and the wide control-word enables.
- R9: A pending flag whose enable is clear does not raise an interrupt. Setting that enable later raises the line one cycle after the write.
- R10: Events and registers of one group never affect the other group's interrupt line.
- R11: Writes to addresses 9..15 change no state, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| evt16_i | input | 12 | Narrow-group cause strobes, bit 3*t+c |
| evt32_i | input | 12 | Wide-group cause strobes, bit 3*t+c |
| irq_tmr16_o | output | 1 | Interrupt line 8, narrow-group level request |
| irq_tmr32_o | output | 1 | Interrupt line 7, wide-group level request |

## Verification
The hardest case to reach from the ports is an event strobe that lands on the same edge as a write-one-to-clear of the same flag. The bench drives both in one cycle, on a flag that is already pending, for a narrow control word and for the status word, and then reads the flag back. A second subtle case is a line that must stay high while one of two requesting timers is cleared. Two timers are made pending and enabled, one is cleared, and the line is sampled on the cycles after the clear before the other timer is cleared too.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int unsigned TMRS_PER_GRP = 4;
  localparam int unsigned CAUSES       = 3;
  localparam int unsigned ADDR_W       = 4;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ENA_LSB      = 12;
  localparam int unsigned PND_LSB      = 16;
  localparam int unsigned WIDE_BASE    = 4;
  localparam int unsigned STAT_ADDR    = 8;
  localparam int unsigned LANE_W       = 8;

  // lane of wide timer k inside the shared status word: timer 0 on top
  function automatic int unsigned stat_lane_lsb(int unsigned k);
    return (TMRS_PER_GRP - 1 - k) * LANE_W;
  endfunction
endpackage

// File: rtl/tirq_group.sv
module tirq_group #(
  parameter int unsigned N = 4,
  parameter int unsigned S = 3,
  localparam int unsigned W = N * S
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_we,
  input  logic [W-1:0] en_wd,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] evt,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend_q
);
  for (genvar t = 0; t < N; t++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[t*S +: S] <= '0;
      end else if (en_we[t]) begin
        en_q[t*S +: S] <= en_wd[t*S +: S];
      end
    end

    // enables change only when written
    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we[t] |=> $stable(en_q[t*S +: S]));
  end

  // event set wins over write-one clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | evt;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    // R4 / R6
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[b] |=> pend_q[b]);
    // R5
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[b] && !evt[b]) |=> !pend_q[b]);
    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[b] && !evt[b]) |=> !pend_q[b]);
  end
endmodule

// File: rtl/tirq_line.sv
module tirq_line #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  output logic         irq
);
  logic req;
  assign req = |(pend & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= req;
  end

  // R7 / R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en)) |=> irq);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |=> !irq);
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg
  import tirq_pkg::*;
#(
  parameter int unsigned N = TMRS_PER_GRP,
  parameter int unsigned S = CAUSES,
  localparam int unsigned W = N * S
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [W-1:0]        evt16_i,
  input  logic [W-1:0]        evt32_i,
  output logic                irq_tmr16_o,
  output logic                irq_tmr32_o
);
  logic [N-1:0] we16, we32;
  logic [W-1:0] wd_en, clr16, clr32;
  logic [W-1:0] en16, pend16, en32, pend32;
  logic         stat_wr;

  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

  for (genvar t = 0; t < N; t++) begin : g_dec
    localparam int unsigned LANE = stat_lane_lsb(t);
    assign we16[t] = reg_wr && (reg_addr == ADDR_W'(t));
    assign we32[t] = reg_wr && (reg_addr == ADDR_W'(WIDE_BASE + t));
    assign wd_en[t*S +: S] = reg_wdata[ENA_LSB +: S];
    assign clr16[t*S +: S] = we16[t] ? reg_wdata[PND_LSB +: S] : '0;
    assign clr32[t*S +: S] = stat_wr ? reg_wdata[LANE +: S] : '0;
  end

  tirq_group #(.N(N), .S(S)) u_grp16 (
    .clk(clk), .rst_n(rst_n), .en_we(we16), .en_wd(wd_en),
    .clr(clr16), .evt(evt16_i), .en_q(en16), .pend_q(pend16));

  tirq_group #(.N(N), .S(S)) u_grp32 (
    .clk(clk), .rst_n(rst_n), .en_we(we32), .en_wd(wd_en),
    .clr(clr32), .evt(evt32_i), .en_q(en32), .pend_q(pend32));

  tirq_line #(.W(W)) u_line16 (
    .clk(clk), .rst_n(rst_n), .pend(pend16), .en(en16), .irq(irq_tmr16_o));

  tirq_line #(.W(W)) u_line32 (
    .clk(clk), .rst_n(rst_n), .pend(pend32), .en(en32), .irq(irq_tmr32_o));

  always_comb begin
    reg_rdata = '0;
    for (int t = 0; t < int'(N); t++) begin
      if (reg_addr == ADDR_W'(t)) begin
        reg_rdata[ENA_LSB +: S] = en16[t*S +: S];
        reg_rdata[PND_LSB +: S] = pend16[t*S +: S];
      end
      if (reg_addr == ADDR_W'(WIDE_BASE + t))
        reg_rdata[ENA_LSB +: S] = en32[t*S +: S];
      if (reg_addr == ADDR_W'(STAT_ADDR))
        reg_rdata[stat_lane_lsb(t) +: S] = pend32[t*S +: S];
    end
  end

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(STAT_ADDR)) |-> (reg_rdata == '0));
  // R10
  grp_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend32 & en32) == '0) |=> !irq_tmr32_o);
endmodule

// File: tb/tmr_irq_agg_tb.sv
module tmr_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] evt16 = '0, evt32 = '0;
  logic        irq16, irq32;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt16_i(evt16),
    .evt32_i(evt32), .irq_tmr16_o(irq16), .irq_tmr32_o(irq32));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(logic [11:0] m16, logic [11:0] m32);
    @(negedge clk);
    evt16 = m16; evt32 = m32;
    @(negedge clk);
    evt16 = '0; evt32 = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 9; a++) rd("R1", 4'(a), 32'h0);
    chk("R1 irq16", {31'b0, irq16}, 32'h0);
    chk("R1 irq32", {31'b0, irq32}, 32'h0);
  endtask

  task automatic t_layout;
    wr(4'd0, 32'hFFFF_FFFF);
    rd("R2", 4'd0, 32'h0000_7000);
    wr(4'd4, 32'hFFFF_FFFF);
    rd("R3", 4'd4, 32'h0000_7000);
    rd("R3 status", 4'd8, 32'h0);
    wr(4'd0, 32'h0); wr(4'd4, 32'h0);
    rd("R2 restore", 4'd0, 32'h0);
  endtask

  task automatic t_narrow;
    pulse(12'h010, 12'h0);              // timer 1 cause 1
    rd("R4", 4'd1, 32'h0002_0000);
    @(negedge clk);
    chk("R9 disabled", {31'b0, irq16}, 32'h0);
    wr(4'd1, 32'h0000_2000);            // enable cause 1, no clear
    rd("R5 enable only", 4'd1, 32'h0002_2000);
    @(negedge clk);
    chk("R9 late enable", {31'b0, irq16}, 32'h1);
    chk("R10 irq32", {31'b0, irq32}, 32'h0);
    wr(4'd1, 32'h0002_2000);            // clear, keep enable
    rd("R5 clear", 4'd1, 32'h0000_2000);
    chk("R7 latency", {31'b0, irq16}, 32'h1);
    @(negedge clk);
    chk("R7 fall", {31'b0, irq16}, 32'h0);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_write_zero;
    pulse(12'h001, 12'h0);
    wr(4'd0, 32'h0);
    rd("R5 write0", 4'd0, 32'h0001_0000);
    wr(4'd0, 32'h0001_0000);
    rd("R5 clear A", 4'd0, 32'h0);
  endtask

  task automatic t_two_timers;
    wr(4'd2, 32'h0000_1000);
    wr(4'd3, 32'h0000_4000);
    pulse(12'h040 | 12'h800, 12'h0);    // timer 2 cause 0, timer 3 cause 2
    @(negedge clk);
    chk("R7 two", {31'b0, irq16}, 32'h1);
    wr(4'd2, 32'h0001_1000);
    @(negedge clk);
    chk("R7 one left", {31'b0, irq16}, 32'h1);
    wr(4'd3, 32'h0004_4000);
    @(negedge clk);
    chk("R7 none left", {31'b0, irq16}, 32'h0);
    wr(4'd2, 32'h0); wr(4'd3, 32'h0);
  endtask

  task automatic t_wide;
    pulse(12'h0, 12'h004 | 12'h008 | 12'h080 | 12'h800);
    rd("R3 lanes", 4'd8, 32'h0401_0204);
    @(negedge clk);
    chk("R8 disabled", {31'b0, irq32}, 32'h0);
    wr(4'd7, 32'h0000_4000);            // wide timer 3 cause 2
    @(negedge clk);
    chk("R8 rise", {31'b0, irq32}, 32'h1);
    chk("R10 irq16", {31'b0, irq16}, 32'h0);
    wr(4'd8, 32'h0000_0004);
    rd("R5 lane clear", 4'd8, 32'h0401_0200);
    @(negedge clk);
    chk("R8 fall", {31'b0, irq32}, 32'h0);
    wr(4'd8, 32'h0707_0707);
    rd("R5 status clear", 4'd8, 32'h0);
    wr(4'd7, 32'h0);
  endtask

  task automatic t_collide;
    pulse(12'h001, 12'h001);
    @(negedge clk);
    evt16 = 12'h001; reg_addr = 4'd0; reg_wdata = 32'h0001_0000; reg_wr = 1'b1;
    @(negedge clk);
    evt16 = '0; reg_wr = 1'b0;
    rd("R6 narrow", 4'd0, 32'h0001_0000);
    @(negedge clk);
    evt32 = 12'h001; reg_addr = 4'd8; reg_wdata = 32'h0100_0000; reg_wr = 1'b1;
    @(negedge clk);
    evt32 = '0; reg_wr = 1'b0;
    rd("R6 wide", 4'd8, 32'h0100_0000);
    wr(4'd0, 32'h0001_0000); wr(4'd8, 32'h0100_0000);
    rd("R6 cleared", 4'd8, 32'h0);
  endtask

  task automatic t_unmapped;
    pulse(12'h002, 12'h0);
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd("R11 read", 4'(a), 32'h0);
    end
    rd("R11 no effect", 4'd0, 32'h0002_0000);
    rd("R11 no effect en", 4'd4, 32'h0);
    wr(4'd0, 32'h0002_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_narrow();
    t_write_zero();
    t_two_timers();
    t_wide();
    t_collide();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule